// File: doc/BRIEF.md
# Saturating Clear-On-Read Port Event Counters

This block keeps one bank of five event counters for a single switch port. Nearby logic pulses single-cycle strobes when the port sends a packet-accepted symbol, sends a packet-not-accepted or packet-retry symbol, finishes sending a packet, sees a packet match the trace criteria, or drops a packet through the filter. Each counter is `CNT_W` bits wide (32 by default). A counter stops at its all-ones value instead of wrapping.

Software reads the counters through a small register port made of an address, a read strobe and a registered read-data bus. A read returns the counter's value and clears it in the same cycle. An event that lands in the same cycle as the read is not lost: it becomes the first count after the clear. The transmit strobe comes with a stomp qualifier. Packets that were cut off with a stomp symbol do not add to the transmitted-packet count.

Top module: `port_stat_counters`

## Requirements
- R1: After reset every counter is zero and `rd_data_o` is zero.
- R2: The accepted counter is at address 0. It adds one for each cycle in which `ack_ok_i` is high.
- R3: The not-accepted counter is at address 1. It adds one for `nack_i` and one for `retry_i`, so it adds two when both are high in the same cycle.
- R4: The transmitted-packet counter is at address 2. It adds one when `pkt_tx_i` is high and `pkt_stomped_i` is low. When `pkt_stomped_i` is high, the strobe is ignored.
- R5: The trace-match counter is at address 3 and counts `trace_hit_i`. The filter-match counter is at address 4 and counts `filter_hit_i`.
- R6: `rd_data_o` takes the addressed counter's value from before the clock edge at which `rd_en_i` is sampled. It holds that value until the next read.
- R7: A read clears the addressed counter to zero. The other counters are not affected.
- R8: An event that arrives in the same cycle as a read of its counter is not lost. The read returns the old value, and the counter then holds that cycle's increment (1 or 2).
- R9: A counter saturates at 2^CNT_W-1 and holds there under further events, including a double increment.
- R10: A read of an address from 5 to 2^ADDR_W-1 returns zero and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ack_ok_i | input | 1 | Packet-accepted symbol sent |
| nack_i | input | 1 | Packet-not-accepted symbol sent |
| retry_i | input | 1 | Packet-retry symbol sent |
| pkt_tx_i | input | 1 | Packet transmission finished |
| pkt_stomped_i | input | 1 | Qualifies `pkt_tx_i`: the packet was stomped |
| trace_hit_i | input | 1 | Packet matched the trace criteria |
| filter_hit_i | input | 1 | Packet was filtered |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Counter address |
| rd_data_o | output | CNT_W | Registered read data |

## Verification
The hardest cases to reach from the ports are saturation under a double increment and a read that clears a counter in the same cycle as its own event. With 32-bit counters, saturation is out of reach in simulation. The bench therefore builds the block with 8-bit counters. It drives long runs of single and paired not-accepted/retry strobes past the limit, then issues reads with the matching event strobe asserted in the same cycle. A seeded random phase then mixes all the strobes with reads to every address, including the unused ones, and checks each result against a model of the bank.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned N_CNT = 5;
  typedef enum logic [2:0] {
    CNT_ACK    = 3'd0,
    CNT_NACK   = 3'd1,
    CNT_TX     = 3'd2,
    CNT_TRACE  = 3'd3,
    CNT_FILTER = 3'd4
  } cnt_sel_e;
endpackage

// File: rtl/stat_event_enc.sv
module stat_event_enc
  import stat_pkg::*;
(
  input  logic                  ack_ok_i,
  input  logic                  nack_i,
  input  logic                  retry_i,
  input  logic                  pkt_tx_i,
  input  logic                  pkt_stomped_i,
  input  logic                  trace_hit_i,
  input  logic                  filter_hit_i,
  output logic [N_CNT-1:0][1:0] inc_o
);
  always_comb begin
    inc_o             = '0;
    inc_o[CNT_ACK]    = {1'b0, ack_ok_i};
    inc_o[CNT_NACK]   = 2'({1'b0, nack_i} + {1'b0, retry_i});
    inc_o[CNT_TX]     = {1'b0, pkt_tx_i & ~pkt_stomped_i};
    inc_o[CNT_TRACE]  = {1'b0, trace_hit_i};
    inc_o[CNT_FILTER] = {1'b0, filter_hit_i};
  end
endmodule

// File: rtl/stat_sat_counter.sv
module stat_sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W:0] MAX_EXT = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    sum = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);
    if (clr_i)              cnt_d = CNT_W'(inc_i);  // event in the read cycle survives the clear
    else if (sum > MAX_EXT) cnt_d = {CNT_W{1'b1}};
    else                    cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stat_rd_port.sv
module stat_rd_port
  import stat_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_en_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  input  logic [N_CNT-1:0][CNT_W-1:0] cnt_i,
  output logic [N_CNT-1:0]            clr_o,
  output logic [CNT_W-1:0]            rd_data_o
);
  logic [CNT_W-1:0] sel;
  logic [CNT_W-1:0] rd_q;

  for (genvar g = 0; g < N_CNT; g++) begin : g_clr
    assign clr_o[g] = rd_en_i && (rd_addr_i == ADDR_W'(g));
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_CNT; i++)
      if (rd_addr_i == ADDR_W'(i)) sel = cnt_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= sel;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/port_stat_counters.sv
module port_stat_counters
  import stat_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_ok_i,
  input  logic              nack_i,
  input  logic              retry_i,
  input  logic              pkt_tx_i,
  input  logic              pkt_stomped_i,
  input  logic              trace_hit_i,
  input  logic              filter_hit_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o
);
  logic [N_CNT-1:0][1:0]       inc;
  logic [N_CNT-1:0]            clr;
  logic [N_CNT-1:0][CNT_W-1:0] cnt;

  stat_event_enc u_enc (
    .ack_ok_i      (ack_ok_i),
    .nack_i        (nack_i),
    .retry_i       (retry_i),
    .pkt_tx_i      (pkt_tx_i),
    .pkt_stomped_i (pkt_stomped_i),
    .trace_hit_i   (trace_hit_i),
    .filter_hit_i  (filter_hit_i),
    .inc_o         (inc)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    stat_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[g]),
      .clr_i  (clr[g]),
      .cnt_o  (cnt[g])
    );
  end

  stat_rd_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .cnt_i     (cnt),
    .clr_o     (clr),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/port_stat_counters_chk.sv
module port_stat_counters_chk
  import stat_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        nack_i,
  input logic                        retry_i,
  input logic                        pkt_tx_i,
  input logic                        pkt_stomped_i,
  input logic                        rd_en_i,
  input logic [ADDR_W-1:0]           rd_addr_i,
  input logic [N_CNT-1:0][CNT_W-1:0] cnt,
  input logic [CNT_W-1:0]            rd_data_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  // R10
  unused_addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (rd_addr_i >= ADDR_W'(N_CNT)) |=> rd_data_o == '0);

  // R6
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R4
  stomp_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_tx_i && pkt_stomped_i && !(rd_en_i && rd_addr_i == ADDR_W'(CNT_TX))
    |=> cnt[CNT_TX] == $past(cnt[CNT_TX]));

  // R3
  dual_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_i && retry_i && !(rd_en_i && rd_addr_i == ADDR_W'(CNT_NACK))
    && cnt[CNT_NACK] < MAX - 1 |=> cnt[CNT_NACK] == $past(cnt[CNT_NACK]) + 2);

  for (genvar g = 0; g < N_CNT; g++) begin : g_prop
    // R9
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt[g] == MAX && !(rd_en_i && rd_addr_i == ADDR_W'(g)) |=> cnt[g] == MAX);
    // R8
    clear_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i && rd_addr_i == ADDR_W'(g) |=> cnt[g] <= 2 && rd_data_o == $past(cnt[g]));
  end
endmodule

bind port_stat_counters port_stat_counters_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .nack_i        (nack_i),
  .retry_i       (retry_i),
  .pkt_tx_i      (pkt_tx_i),
  .pkt_stomped_i (pkt_stomped_i),
  .rd_en_i       (rd_en_i),
  .rd_addr_i     (rd_addr_i),
  .cnt           (cnt),
  .rd_data_o     (rd_data_o)
);

// File: tb/sim_port_stat_counters.sv
`timescale 1ns/1ps
module sim_port_stat_counters;
  localparam int unsigned CW = 8;
  localparam int unsigned AW = 3;
  localparam int unsigned MAXV = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic ack, nack, retry, tx, stomp, trace, filt, rd;
  logic [AW-1:0] addr;
  logic [CW-1:0] rdata;

  int checks = 0, errors = 0;
  int model [5];
  int exp_rd = 0;
  bit done = 0;

  always #5 clk = ~clk;

  port_stat_counters #(.CNT_W(CW), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ack_ok_i(ack), .nack_i(nack), .retry_i(retry),
    .pkt_tx_i(tx), .pkt_stomped_i(stomp), .trace_hit_i(trace), .filter_hit_i(filt),
    .rd_en_i(rd), .rd_addr_i(addr), .rd_data_o(rdata));

  function automatic int sat_add(int v, int d);
    return (v + d > int'(MAXV)) ? int'(MAXV) : v + d;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit a, bit n, bit r, bit t, bit s, bit tr, bit f,
                      bit rden, int ad, string req);
    int incs [5];
    ack = a; nack = n; retry = r; tx = t; stomp = s; trace = tr; filt = f;
    rd = rden; addr = AW'(ad);
    incs[0] = int'(a); incs[1] = int'(n) + int'(r); incs[2] = int'(t && !s);
    incs[3] = int'(tr); incs[4] = int'(f);
    @(posedge clk);
    if (rden) exp_rd = (ad < 5) ? model[ad] : 0;
    for (int i = 0; i < 5; i++)
      model[i] = (rden && ad == i) ? incs[i] : sat_add(model[i], incs[i]);
    #1;
    if (rden) check(req, int'(rdata), exp_rd);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0,0,0,0,0,0,0,0,0,"");
  endtask

  task automatic rd_cnt(int ad, string req);
    step(0,0,0,0,0,0,0,1,ad,req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    {ack, nack, retry, tx, stomp, trace, filt, rd} = '0;
    addr = '0;
    for (int i = 0; i < 5; i++) model[i] = 0;
    #23 rst_n = 1;
    @(negedge clk);
    check("R1 rd_data", int'(rdata), 0);
    for (int i = 0; i < 5; i++) rd_cnt(i, "R1 reset counter");

    // R2 accepted count, R7 cleared by read
    repeat (3) step(1,0,0,0,0,0,0,0,0,"");
    rd_cnt(0, "R2 accepted count");
    rd_cnt(0, "R7 cleared after read");

    // R3 merged not-accepted / retry
    step(0,1,1,0,0,0,0,0,0,"");
    step(0,1,0,0,0,0,0,0,0,"");
    step(0,0,1,0,0,0,0,0,0,"");
    rd_cnt(1, "R3 nack+retry");

    // R4 stomp qualifier
    repeat (2) step(0,0,0,1,0,0,0,0,0,"");
    repeat (3) step(0,0,0,1,1,0,0,0,0,"");
    step(0,0,0,0,1,0,0,0,0,"");
    rd_cnt(2, "R4 stomped ignored");

    // R5 trace and filter
    repeat (4) step(0,0,0,0,0,1,0,0,0,"");
    step(0,0,0,0,0,0,1,0,0,"");
    rd_cnt(3, "R5 trace");
    rd_cnt(4, "R5 filter");

    // R6 read data holds between reads
    repeat (5) step(1,0,0,0,0,0,0,0,0,"");
    rd_cnt(0, "R6 read value");
    repeat (4) step(1,1,0,1,0,1,1,0,0,"");
    check("R6 hold", int'(rdata), 5);

    // R7 other counters untouched by a read
    rd_cnt(1, "R7 neighbour kept");
    rd_cnt(2, "R7 neighbour kept");

    // R8 event coincident with read
    repeat (2) step(1,0,0,0,0,0,0,0,0,"");
    step(1,0,0,0,0,0,0,1,0,"R8 read returns old");
    rd_cnt(0, "R8 event kept after clear");
    step(0,1,1,0,0,0,0,1,1,"R8 dual read");
    rd_cnt(1, "R8 dual kept");

    // R10 unused addresses
    rd_cnt(3, "R10 prep");
    repeat (2) step(0,0,0,0,0,1,0,0,0,"");
    for (int ad = 5; ad < 8; ad++) rd_cnt(ad, "R10 unused reads zero");
    rd_cnt(3, "R10 no side effect");

    // R9 saturation
    repeat (MAXV + 40) step(1,0,0,0,0,0,0,0,0,"");
    rd_cnt(0, "R9 single saturate");
    repeat (MAXV / 2) step(0,1,1,0,0,0,0,0,0,"");
    step(0,1,0,0,0,0,0,0,0,"");
    rd_cnt(1, "R9 exact max");
    repeat (MAXV / 2 + 3) step(0,1,1,0,0,0,0,0,0,"");
    rd_cnt(1, "R9 dual saturate");
    repeat (MAXV + 5) step(0,0,0,0,0,1,1,0,0,"");
    step(0,0,0,0,0,1,1,1,3,"R9 R8 read at max");
    rd_cnt(4, "R9 filter max");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit r = ($urandom % 8) == 0;
      step($urandom%2, $urandom%2, $urandom%2, $urandom%2, $urandom%2,
           $urandom%2, $urandom%2, r, int'($urandom % 8), "R2 R3 R4 R5 R6 R7 R8 R10 random");
    end
    for (int i = 0; i < 5; i++) rd_cnt(i, "R7 final drain");
    idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule